// File: doc/BRIEF.md
# Delay-Line TDC Hit Decoder and Timestamper

This block is the digital back end of a delay-line time-to-digital converter. On every reference clock edge it takes the 128-tap snapshot of the delay chain. In that snapshot a hit shows up as a stretch of ones with zeros around it. The block does the following for each snapshot:

- It cleans single-tap bubbles out of the snapshot.
- It finds the tap where the stretch begins.
- It measures how long the stretch is.
- It stamps the result with the count of reference cycles since reset.

No trigger is involved. Every snapshot that holds a hit produces a record by itself. Each record is pushed into a small FIFO that is read through a valid/ready stream.

The timestamp is the coarse cycle count with the 7-bit fine bin appended as its least significant part. One fine bin is one 128th of the reference period. A pulse that is still high at the last tap spills into the next snapshot. That continuation is not reported a second time.

Top module: `tdc_hit_timestamper`

## Requirements
- R1: After synchronous reset, `out_valid` and `ovf_flag` are 0, and the first snapshot sampled after reset release carries coarse count 0.
- R2: Before encoding, each interior tap i (1..126) is replaced by the majority of taps i-1, i and i+1. Taps 0 and 127 pass unchanged, so a lone 0 inside a stretch and a lone 1 outside one both vanish.
- R3: The fine index is the lowest tap i of the cleaned snapshot where tap i is 1 and its lower neighbour is 0, or where i is 0. `out_timestamp` equals {coarse[31:0], fine[6:0]}.
- R4: `out_run_len` is the number of consecutive ones in the cleaned snapshot, counted from the fine index upward.
- R5: When the cleaned snapshot has more than one stretch start (a suppressed continuation does not count), `out_multi` is 1 and the record still reports the lowest start.
- R6: If tap 127 of the previous cleaned snapshot was 1, a stretch starting at tap 0 is a continuation and is not reported. If no other stretch is present, no record is produced.
- R7: A cleaned snapshot with no stretch start produces no record.
- R8: The coarse field equals the number of clock edges with reset low before the edge that sampled the snapshot, modulo 2^32.
- R9: Records leave in arrival order. While `out_valid` is 1 and `out_ready` is 0, the output holds its value.
- R10: The FIFO holds 16 records. A record arriving while 16 are held is dropped, even if one is read on the same edge. A drop sets `ovf_flag`, which stays set until `ovf_clear` is sampled high. A drop on the same edge as the clear wins.
- R11: With an empty FIFO and `out_ready` high, a snapshot sampled at edge k makes `out_valid` rise after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| taps_in | input | 128 | Latched delay-chain snapshot, tap 0 first in time |
| out_valid | output | 1 | Record available at the FIFO head |
| out_ready | input | 1 | Consumer accepts the head record |
| out_timestamp | output | 39 | Coarse count and fine bin |
| out_run_len | output | 8 | Length of the reported stretch in taps |
| out_multi | output | 1 | More than one stretch seen in the snapshot |
| ovf_flag | output | 1 | Sticky record-drop indicator |
| ovf_clear | input | 1 | Clears the drop indicator |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- Bubbles. A wrong filter would split one stretch into two, raising `out_multi` and shortening the run length, or would report a lone stray one as a hit.
- A pulse straddling the end of the chain. A design without the continuation rule would emit a second record at fine bin 0 one cycle later.
- A fresh stretch at tap 0 after a quiet cycle. A design that over-suppresses would lose that record.
- Overflow with the consumer stalled. A FIFO that overwrote entries or failed to latch the flag would show wrong data on drain or a cleared flag.
- Latency and coarse count. Both are checked against a cycle count kept in the bench, so any off-by-one in the pipeline shows up as a wrong timestamp.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int TDC_TAPS = 128;
    localparam int FINE_W   = $clog2(TDC_TAPS);
    localparam int LEN_W    = FINE_W + 1;
    localparam int COARSE_W = 32;
    localparam int STAMP_W  = COARSE_W + FINE_W;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
        logic [LEN_W-1:0]    run_len;
        logic                multi;
    } tdc_rec_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tdc_bubble_fix.sv
module tdc_bubble_fix
    import tdc_pkg::*;
#(
    parameter int N = TDC_TAPS
) (
    input  logic [N-1:0] raw,
    output logic [N-1:0] clean
);

    for (genvar i = 0; i < N; i++) begin : g_tap
        if (i == 0 || i == N - 1) begin : g_edge
            assign clean[i] = raw[i];
        end else begin : g_mid
            assign clean[i] = maj3(raw[i-1], raw[i], raw[i+1]);
        end
    end

endmodule

// File: rtl/tdc_edge_encoder.sv
module tdc_edge_encoder
    import tdc_pkg::*;
#(
    parameter int N = TDC_TAPS
) (
    input  logic [N-1:0]       clean,
    input  logic               carry_in,
    output logic               hit,
    output logic [FINE_W-1:0]  fine,
    output logic [LEN_W-1:0]   run_len,
    output logic               multi
);

    logic [N-1:0] starts;
    logic [N-1:0] starts_eff;

    always_comb begin
        starts     = clean & ~{clean[N-2:0], 1'b0};
        starts_eff = starts & ~{{(N-1){1'b0}}, carry_in};
        hit        = |starts_eff;
        multi      = |(starts_eff & (starts_eff - N'(1)));
    end

    always_comb begin
        fine = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (starts_eff[i]) fine = FINE_W'(i);
        end
    end

    always_comb begin
        logic found;
        logic running;
        found   = 1'b0;
        running = 1'b0;
        run_len = '0;
        for (int i = 0; i < N; i++) begin
            if (starts_eff[i] && !found) begin
                found   = 1'b1;
                running = 1'b1;
            end
            if (running) begin
                if (clean[i]) run_len = run_len + LEN_W'(1);
                else          running = 1'b0;
            end
        end
    end

endmodule

// File: rtl/tdc_rec_fifo.sv
module tdc_rec_fifo
    import tdc_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_req,
    input  tdc_rec_t wr_data,
    output logic     rd_valid,
    input  logic     rd_ready,
    output tdc_rec_t rd_data,
    input  logic     ovf_clr,
    output logic     ovf_q
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tdc_rec_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   cnt;
    logic            full, push, pop;

    assign full     = (cnt == CW'(DEPTH));
    assign push     = wr_req && !full;
    assign rd_valid = (cnt != '0);
    assign pop      = rd_valid && rd_ready;
    assign rd_data  = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
            if (wr_req && full) ovf_q <= 1'b1;
            else if (ovf_clr)   ovf_q <= 1'b0;
        end
    end

    p_drop_sets_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && full) |=> ovf_q);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ovf_clr) |=> ovf_q);

    p_head_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/tdc_hit_timestamper.sv
module tdc_hit_timestamper
    import tdc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TDC_TAPS-1:0] taps_in,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [STAMP_W-1:0]  out_timestamp,
    output logic [LEN_W-1:0]    out_run_len,
    output logic                out_multi,
    output logic                ovf_flag,
    input  logic                ovf_clear
);

    logic [COARSE_W-1:0] coarse_q;
    logic [TDC_TAPS-1:0] snap_q;
    logic [COARSE_W-1:0] snap_coarse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_q      <= '0;
            snap_q        <= '0;
            snap_coarse_q <= '0;
        end else begin
            coarse_q      <= coarse_q + COARSE_W'(1);
            snap_q        <= taps_in;
            snap_coarse_q <= coarse_q;
        end
    end

    logic [TDC_TAPS-1:0] clean;
    logic                carry_q;
    logic                hit_w, multi_w;
    logic [FINE_W-1:0]   fine_w;
    logic [LEN_W-1:0]    len_w;

    tdc_bubble_fix #(.N(TDC_TAPS)) i_fix (
        .raw   (snap_q),
        .clean (clean)
    );

    tdc_edge_encoder #(.N(TDC_TAPS)) i_enc (
        .clean    (clean),
        .carry_in (carry_q),
        .hit      (hit_w),
        .fine     (fine_w),
        .run_len  (len_w),
        .multi    (multi_w)
    );

    tdc_rec_t rec_q;
    logic     rec_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q     <= '0;
            rec_vld_q <= 1'b0;
            carry_q   <= 1'b0;
        end else begin
            rec_vld_q     <= hit_w;
            rec_q.coarse  <= snap_coarse_q;
            rec_q.fine    <= fine_w;
            rec_q.run_len <= len_w;
            rec_q.multi   <= multi_w;
            carry_q       <= clean[TDC_TAPS-1];
        end
    end

    tdc_rec_t head;

    tdc_rec_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (rec_vld_q),
        .wr_data  (rec_q),
        .rd_valid (out_valid),
        .rd_ready (out_ready),
        .rd_data  (head),
        .ovf_clr  (ovf_clear),
        .ovf_q    (ovf_flag)
    );

    assign out_timestamp = {head.coarse, head.fine};
    assign out_run_len   = head.run_len;
    assign out_multi     = head.multi;

    p_coarse_step_r8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> coarse_q == $past(coarse_q) + COARSE_W'(1));

    p_carry_masks_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (hit_w && carry_q) |-> (fine_w != '0));

    p_multi_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
        multi_w |-> hit_w);

    p_len_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        hit_w |-> (len_w != '0));

endmodule

// File: tb/test_tdc_hit_timestamper.sv
`timescale 1ns/1ps
module test_tdc_hit_timestamper;
    import tdc_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [TDC_TAPS-1:0] taps_in = '0;
    logic                out_valid;
    logic                out_ready = 1'b0;
    logic [STAMP_W-1:0]  out_timestamp;
    logic [LEN_W-1:0]    out_run_len;
    logic                out_multi;
    logic                ovf_flag;
    logic                ovf_clear = 1'b0;

    always #2 clk = ~clk;

    tdc_hit_timestamper i_tdc_hit_timestamper (
        .clk(clk), .rst(rst), .taps_in(taps_in),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_timestamp(out_timestamp), .out_run_len(out_run_len),
        .out_multi(out_multi), .ovf_flag(ovf_flag), .ovf_clear(ovf_clear)
    );

    typedef struct {
        logic [STAMP_W-1:0] ts;
        int                 len;
        bit                 multi;
    } exp_t;

    exp_t   q[$];
    int     n_chk = 0, n_fail = 0, pops = 0, budget = -1;
    int     cyc = 0;
    bit     m_carry = 1'b0;
    string  tag = "R3";

    task automatic chk(input bit ok, input string t, input longint act, input longint ex);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, ex);
        end
    endtask

    // Spec-level model: majority filter, lowest start, run length, continuation rule.
    task automatic ref_decode(input logic [TDC_TAPS-1:0] s, input bit cin,
                              output bit hit, output int fine, output int len,
                              output bit multi, output bit cout);
        logic [TDC_TAPS-1:0] c;
        int nst;
        c = s;
        for (int i = 1; i < TDC_TAPS - 1; i++)
            c[i] = (s[i-1] & s[i]) | (s[i-1] & s[i+1]) | (s[i] & s[i+1]);
        nst = 0; fine = -1; len = 0;
        for (int i = 0; i < TDC_TAPS; i++) begin
            if (c[i] && ((i == 0) ? !cin : !c[i-1])) begin
                nst++;
                if (fine < 0) fine = i;
            end
        end
        hit = (nst > 0);
        multi = (nst > 1);
        if (hit) for (int j = fine; j < TDC_TAPS && c[j]; j++) len++;
        cout = c[TDC_TAPS-1];
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic [TDC_TAPS-1:0] s, input bit rdy);
        bit h, mu, co; int f, l; exp_t e;
        if (out_valid && rdy) begin
            pops++;
            if (q.size() == 0) chk(0, "R9 unexpected record", longint'(out_timestamp), 0);
            else begin
                e = q.pop_front();
                chk(out_timestamp == e.ts, {tag, "/R3/R8 timestamp"}, longint'(out_timestamp), longint'(e.ts));
                chk(int'(out_run_len) == e.len, {tag, "/R4 run length"}, longint'(out_run_len), e.len);
                chk(out_multi == e.multi, {tag, "/R5 multi"}, longint'(out_multi), longint'(e.multi));
            end
        end
        taps_in = s;
        out_ready = rdy;
        ref_decode(s, m_carry, h, f, l, mu, co);
        m_carry = co;
        if (h && budget != 0) begin
            e.ts = {cyc[COARSE_W-1:0], f[FINE_W-1:0]};
            e.len = l; e.multi = mu;
            q.push_back(e);
            if (budget > 0) budget--;
        end
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    function automatic logic [TDC_TAPS-1:0] run(input int lo, input int hi);
        logic [TDC_TAPS-1:0] v = '0;
        for (int i = lo; i <= hi && i < TDC_TAPS; i++) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [TDC_TAPS-1:0] rnd_snap();
        logic [TDC_TAPS-1:0] v = '0;
        int st;
        if ($urandom % 4 == 0) begin
            st = $urandom % TDC_TAPS;
            v = run(st, st + 1 + $urandom % 20);
            if ($urandom % 5 == 0) begin
                st = $urandom % TDC_TAPS;
                v |= run(st, st + 2 + $urandom % 6);
            end
            if ($urandom % 2 == 0) v[$urandom % TDC_TAPS] ^= 1'b1;
        end else if ($urandom % 8 == 0) begin
            v[$urandom % TDC_TAPS] = 1'b1;
        end
        return v;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int p0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
        chk(ovf_flag == 1'b0, "R1 ovf_flag", longint'(ovf_flag), 0);

        // R11 latency, first record carries coarse 0 (R1)
        tag = "R1/R11";
        step(run(10, 19), 1'b1);
        chk(out_valid == 1'b0, "R11 valid after edge k", longint'(out_valid), 0);
        step('0, 1'b1);
        chk(out_valid == 1'b0, "R11 valid after edge k+1", longint'(out_valid), 0);
        step('0, 1'b1);
        chk(out_valid == 1'b1, "R11 valid after edge k+2", longint'(out_valid), 1);
        step('0, 1'b1);

        // R7: stray lone one and empty snapshot give nothing
        tag = "R7";
        p0 = pops;
        step(run(60, 60), 1'b1);
        step('0, 1'b1);
        repeat (4) step('0, 1'b1);
        chk(pops == p0, "R7 no record", pops - p0, 0);

        // R2: bubbles inside and outside a stretch
        tag = "R2";
        begin
            logic [TDC_TAPS-1:0] b;
            b = run(30, 40); b[35] = 1'b0; b[80] = 1'b1;
            step(b, 1'b1);
        end
        repeat (4) step('0, 1'b1);

        // R5: two stretches
        tag = "R5";
        step(run(10, 15) | run(40, 50), 1'b1);
        repeat (4) step('0, 1'b1);

        // R6: continuation suppressed, fresh tap-0 start kept
        tag = "R6";
        p0 = pops;
        step(run(120, 127), 1'b1);
        step(run(0, 5), 1'b1);
        repeat (5) step('0, 1'b1);
        chk(pops - p0 == 1, "R6 one record across boundary", pops - p0, 1);
        p0 = pops;
        step(run(0, 5), 1'b1);
        repeat (5) step('0, 1'b1);
        chk(pops - p0 == 1, "R6 fresh start at tap 0", pops - p0, 1);
        step(run(125, 127), 1'b1);
        step(run(0, 3) | run(50, 55), 1'b1);
        repeat (5) step('0, 1'b1);

        // R10: overflow with consumer stalled
        tag = "R10";
        budget = FIFO_DEPTH_BENCH;
        for (int k = 0; k < 20; k++) step(run(k * 5 + 2, k * 5 + 4), 1'b0);
        repeat (4) step('0, 1'b0);
        budget = -1;
        chk(ovf_flag == 1'b1, "R10 flag set", longint'(ovf_flag), 1);
        chk(out_valid == 1'b1, "R9 held while stalled", longint'(out_valid), 1);
        p0 = pops;
        repeat (20) step('0, 1'b1);
        chk(pops - p0 == 16, "R10 sixteen kept", pops - p0, 16);
        chk(ovf_flag == 1'b1, "R10 flag sticky", longint'(ovf_flag), 1);
        ovf_clear = 1'b1;
        step('0, 1'b1);
        ovf_clear = 1'b0;
        chk(ovf_flag == 1'b0, "R10 flag cleared", longint'(ovf_flag), 0);

        // Random phase: R2 R3 R4 R5 R6 R8 R9
        tag = "R9";
        for (int k = 0; k < 4000; k++) step(rnd_snap(), ($urandom % 10) < 7);
        repeat (40) step('0, 1'b1);
        chk(q.size() == 0, "R9 all records delivered", q.size(), 0);
        chk(ovf_flag == 1'b0, "R10 no drop at light load", longint'(ovf_flag), 0);
        summary();
    end

    localparam int FIFO_DEPTH_BENCH = 16;

endmodule